// File: doc/BRIEF.md
# Tile-Map Pixel Fetcher

This block produces the colour stream for the visible part of each scan line of a small tiled display. The screen is not stored as pixels. A tile map holds one 16-bit pointer per screen cell, and each pointer gives the start of an 8x8 tile pattern held in a separate pattern memory. Each pixel is 4 bits, so a pattern byte carries two pixels and one row of a tile takes four bytes. For every visible line the block reads the map entries of the current tile row. It adds the row-within-tile offset to each pointer, reads the pattern bytes, and presents one pixel every `CLK_PER_PIX` clocks.

An external timing generator supplies a frame-start pulse and a line-start pulse for each line. Two maps of `TILES_X*TILES_Y` entries share the map address space, buffer 1 directly above buffer 0. A select input picks the displayed map at frame start, so software can rewrite the hidden map without tearing. Both memory ports are synchronous, with data returned on the clock after a read strobe. A map entry whose low byte has bit 7 set refers to pixel data held in RAM. The block raises a flag while such a tile is on screen but still fetches it as a pattern.

Top module: `tilemap_pixel_fetch`

## Requirements
- R1: On a visible line, pixel k (0-based) appears on `pix` starting 3 + CLK_PER_PIX*k clocks after the edge that samples `line_start`, and holds for CLK_PER_PIX clocks.
- R2: Each pattern byte yields its bits 3:0 first and then bits 7:4. The four bytes of a tile row are shown in increasing address order.
- R3: The pattern address of byte b (0..3) of a tile on line y is pointer + 4*(y mod 8) + b, a full 16-bit sum in which a carry out of bit 7 reaches the upper byte.
- R4: Column c of line y takes map entry buffer*TILES_X*TILES_Y + (y div 8)*TILES_X + c, so the row base moves by TILES_X entries every 8 lines.
- R5: `pix_valid` stays high for exactly TILES_X*8 consecutive pixel periods per visible line, with no gap at tile boundaries.
- R6: `buf_sel` is taken only in the cycle where `frame_start` is high. Changes at other times leave the rest of the frame on the same map.
- R7: `ram_tile` equals bit 7 of the pointer of the tile whose pixels are being shown, and is low whenever `pix_valid` is low.
- R8: After reset, between lines, and on every line from index TILES_Y*8 onward, `pix` is 0 and `pix_valid` is low.
- R9: A visible line makes exactly TILES_X map reads and 4*TILES_X pattern reads. A line past the visible rows makes none.
- R10: A `frame_start` pulse restarts line counting, so the next line is line 0 of the selected map even if the previous frame was cut short.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-clock pulse at the start of a frame |
| line_start | input | 1 | One-clock pulse at the start of each line's active window |
| buf_sel | input | 1 | Map buffer to display from the next frame start |
| map_rd | output | 1 | Tile-map read strobe |
| map_addr | output | $clog2(2*TILES_X*TILES_Y) | Tile-map word address |
| map_data | input | 16 | Tile-map word, valid the clock after `map_rd` |
| pat_rd | output | 1 | Pattern-memory read strobe |
| pat_addr | output | 16 | Pattern byte address |
| pat_data | input | 8 | Pattern byte, valid the clock after `pat_rd` |
| pix | output | 4 | Colour of the current pixel, 0 when blank |
| pix_valid | output | 1 | High while active pixels are driven |
| ram_tile | output | 1 | Current tile pointer refers to RAM pixel data |

## Verification
The bench builds the block with TILES_X=4, TILES_Y=3 and CLK_PER_PIX=3. A whole frame is then only 24 visible lines of 32 pixels, so every clock of every pixel of every line in several complete frames can be compared against values computed from the map contents. The pointers are chosen so that some low bytes overflow when the line offset is added, and so that bit 7 is mixed across tiles. The frames also cover a select change mid-frame, both buffers, lines past the visible rows, and a frame cut short by a new frame start.

// File: rtl/tmf_pkg.sv
package tmf_pkg;
  localparam int PIX_W         = 4;
  localparam int TILE_W        = 8;
  localparam int TILE_H        = 8;
  localparam int BYTES_PER_ROW = TILE_W * PIX_W / 8;
  localparam int BIDX_W        = $clog2(BYTES_PER_ROW);
  localparam int LINE_W        = $clog2(TILE_H);
  localparam int PTR_W         = 16;
  localparam int RAM_FLAG_BIT  = 7;

  typedef logic [PTR_W-1:0] ptr_t;

  typedef enum logic [1:0] {
    LD_IDLE,
    LD_MAP,
    LD_PTR,
    LD_BYTE
  } lead_e;

  // byte address inside the pattern store: pointer + row offset + byte index
  function automatic ptr_t pat_address(ptr_t base, logic [LINE_W-1:0] line,
                                       logic [BIDX_W-1:0] bidx);
    return base + PTR_W'(line) * PTR_W'(BYTES_PER_ROW) + PTR_W'(bidx);
  endfunction

  function automatic logic is_ram_ptr(ptr_t p);
    return p[RAM_FLAG_BIT];
  endfunction

  function automatic logic [PIX_W-1:0] pick_nibble(logic [7:0] b, logic hi);
    return hi ? b[7:4] : b[3:0];
  endfunction
endpackage

// File: rtl/tmf_raster.sv
module tmf_raster import tmf_pkg::*; #(
  parameter int TILES_X = 12,
  parameter int TILES_Y = 12,
  parameter int MAP_AW  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic              buf_sel,
  output logic              line_go,
  output logic [LINE_W-1:0] go_line,
  output logic [MAP_AW-1:0] go_base,
  output logic              buf_act
);
  localparam int ROW_W = $clog2(TILES_Y + 1);
  localparam logic [MAP_AW-1:0] BUF1_BASE = MAP_AW'(TILES_X * TILES_Y);

  logic              buf_q,  eff_buf;
  logic [ROW_W-1:0]  row_q,  eff_row;
  logic [LINE_W-1:0] lin_q,  eff_lin;
  logic [MAP_AW-1:0] rb_q,   eff_rb;

  // a frame start zeroes the counters before the same-cycle line uses them
  always_comb begin
    if (frame_start) begin
      eff_buf = buf_sel;
      eff_row = '0;
      eff_lin = '0;
      eff_rb  = '0;
    end else begin
      eff_buf = buf_q;
      eff_row = row_q;
      eff_lin = lin_q;
      eff_rb  = rb_q;
    end
    line_go = line_start && (eff_row < ROW_W'(TILES_Y));
    go_line = eff_lin;
    go_base = (eff_buf ? BUF1_BASE : '0) + eff_rb;
  end

  assign buf_act = buf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q <= 1'b0;
      row_q <= '0;
      lin_q <= '0;
      rb_q  <= '0;
    end else begin
      buf_q <= eff_buf;
      row_q <= eff_row;
      lin_q <= eff_lin;
      rb_q  <= eff_rb;
      if (line_go) begin
        if (eff_lin == LINE_W'(TILE_H - 1)) begin
          lin_q <= '0;
          row_q <= eff_row + ROW_W'(1);
          rb_q  <= eff_rb + MAP_AW'(TILES_X);
        end else begin
          lin_q <= eff_lin + LINE_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/tmf_pixclk.sv
module tmf_pixclk import tmf_pkg::*; #(
  parameter int CLK_PER_PIX = 5,
  parameter int NPIX        = 96,
  localparam int PC_W       = $clog2(NPIX),
  localparam int COL_W      = PC_W - BIDX_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              start,
  output logic              running,
  output logic              pix_step,
  output logic              line_last,
  output logic              phase0,
  output logic              hi_nib,
  output logic [BIDX_W-1:0] bidx,
  output logic [COL_W-1:0]  tile_col
);
  localparam int TK_W = $clog2(CLK_PER_PIX + 1);

  logic [TK_W-1:0] tick;
  logic [PC_W-1:0] pcount;

  assign pix_step  = running && (tick == TK_W'(CLK_PER_PIX - 1));
  assign line_last = pix_step && (pcount == PC_W'(NPIX - 1));
  assign phase0    = running && (tick == '0) && !pcount[0];
  assign hi_nib    = pcount[0];
  assign bidx      = pcount[BIDX_W:1];
  assign tile_col  = pcount[PC_W-1:BIDX_W+1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      tick    <= '0;
      pcount  <= '0;
    end else if (clear) begin
      running <= 1'b0;
      tick    <= '0;
      pcount  <= '0;
    end else if (start) begin
      running <= 1'b1;
      tick    <= '0;
      pcount  <= '0;
    end else if (running) begin
      if (pix_step) begin
        tick <= '0;
        if (line_last) begin
          running <= 1'b0;
          pcount  <= '0;
        end else begin
          pcount <= pcount + PC_W'(1);
        end
      end else begin
        tick <= tick + TK_W'(1);
      end
    end
  end
endmodule

// File: rtl/tmf_fetch.sv
module tmf_fetch import tmf_pkg::*; #(
  parameter int TILES_X = 12,
  parameter int MAP_AW  = 9,
  parameter int COL_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_go,
  input  logic [LINE_W-1:0] go_line,
  input  logic [MAP_AW-1:0] go_base,
  input  logic              phase0,
  input  logic              pix_step,
  input  logic              hi_nib,
  input  logic              line_last,
  input  logic [BIDX_W-1:0] bidx,
  input  logic [COL_W-1:0]  tile_col,
  input  ptr_t              map_data,
  input  logic [7:0]        pat_data,
  output logic              start,
  output logic              map_rd,
  output logic [MAP_AW-1:0] map_addr,
  output logic              pat_rd,
  output ptr_t              pat_addr,
  output logic [7:0]        cur_byte,
  output logic              cur_ram,
  output logic              busy
);
  lead_e             st;
  logic [LINE_W-1:0] lin;
  logic [MAP_AW-1:0] base;
  ptr_t              cur_ptr, nxt_ptr;
  logic [7:0]        nxt_byte;
  logic              pend_pat, pend_map;

  logic last_col, tile_end, run_pat, run_map, byte_end;

  always_comb begin
    last_col = (tile_col == COL_W'(TILES_X - 1));
    tile_end = (bidx == '1);
    run_pat  = phase0 && !(last_col && tile_end);
    run_map  = phase0 && (bidx == '0) && !last_col;
    byte_end = pix_step && hi_nib && !line_last;

    map_rd   = (st == LD_MAP) || run_map;
    map_addr = (st == LD_MAP) ? base
                              : base + MAP_AW'(tile_col) + MAP_AW'(1);

    pat_rd   = (st == LD_PTR) || run_pat;
    if (st == LD_PTR)
      pat_addr = pat_address(map_data, lin, '0);
    else if (tile_end)
      pat_addr = pat_address(nxt_ptr, lin, '0);
    else
      pat_addr = pat_address(cur_ptr, lin, bidx + BIDX_W'(1));

    start   = (st == LD_BYTE);
    busy    = (st != LD_IDLE);
    cur_ram = is_ram_ptr(cur_ptr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= LD_IDLE;
      lin      <= '0;
      base     <= '0;
      cur_ptr  <= '0;
      nxt_ptr  <= '0;
      cur_byte <= '0;
      nxt_byte <= '0;
      pend_pat <= 1'b0;
      pend_map <= 1'b0;
    end else begin
      pend_pat <= run_pat;
      pend_map <= run_map;
      if (pend_pat) nxt_byte <= pat_data;
      if (pend_map) nxt_ptr  <= map_data;
      if (byte_end) begin
        cur_byte <= nxt_byte;
        if (tile_end) cur_ptr <= nxt_ptr;
      end
      if (line_go) begin
        st       <= LD_MAP;
        lin      <= go_line;
        base     <= go_base;
        pend_pat <= 1'b0;
        pend_map <= 1'b0;
      end else begin
        case (st)
          LD_MAP:  st <= LD_PTR;
          LD_PTR: begin
            cur_ptr <= map_data;
            st      <= LD_BYTE;
          end
          LD_BYTE: begin
            cur_byte <= pat_data;
            st       <= LD_IDLE;
          end
          default: st <= LD_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/tmf_shift.sv
module tmf_shift import tmf_pkg::*; (
  input  logic             running,
  input  logic             hi_nib,
  input  logic [7:0]       cur_byte,
  input  logic             cur_ram,
  output logic [PIX_W-1:0] pix,
  output logic             pix_valid,
  output logic             ram_tile
);
  always_comb begin
    pix       = running ? pick_nibble(cur_byte, hi_nib) : '0;
    pix_valid = running;
    ram_tile  = running && cur_ram;
  end
endmodule

// File: rtl/tilemap_pixel_fetch.sv
module tilemap_pixel_fetch import tmf_pkg::*; #(
  parameter int TILES_X     = 12,
  parameter int TILES_Y     = 12,
  parameter int CLK_PER_PIX = 5,
  localparam int MAP_AW     = $clog2(2 * TILES_X * TILES_Y)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic              buf_sel,
  output logic              map_rd,
  output logic [MAP_AW-1:0] map_addr,
  input  logic [PTR_W-1:0]  map_data,
  output logic              pat_rd,
  output logic [PTR_W-1:0]  pat_addr,
  input  logic [7:0]        pat_data,
  output logic [PIX_W-1:0]  pix,
  output logic              pix_valid,
  output logic              ram_tile
);
  localparam int NPIX  = TILES_X * TILE_W;
  localparam int PC_W  = $clog2(NPIX);
  localparam int COL_W = PC_W - BIDX_W - 1;

  logic              line_go, buf_act;
  logic [LINE_W-1:0] go_line;
  logic [MAP_AW-1:0] go_base;
  logic              running, pix_step, line_last, phase0, hi_nib;
  logic [BIDX_W-1:0] bidx;
  logic [COL_W-1:0]  tile_col;
  logic              start, fetch_busy, cur_ram, busy_w;
  logic [7:0]        cur_byte;

  tmf_raster #(.TILES_X(TILES_X), .TILES_Y(TILES_Y), .MAP_AW(MAP_AW)) u_raster (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
    .buf_sel(buf_sel), .line_go(line_go), .go_line(go_line), .go_base(go_base),
    .buf_act(buf_act)
  );

  tmf_pixclk #(.CLK_PER_PIX(CLK_PER_PIX), .NPIX(NPIX)) u_pixclk (
    .clk(clk), .rst_n(rst_n), .clear(line_go), .start(start), .running(running),
    .pix_step(pix_step), .line_last(line_last), .phase0(phase0), .hi_nib(hi_nib),
    .bidx(bidx), .tile_col(tile_col)
  );

  tmf_fetch #(.TILES_X(TILES_X), .MAP_AW(MAP_AW), .COL_W(COL_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .line_go(line_go), .go_line(go_line), .go_base(go_base),
    .phase0(phase0), .pix_step(pix_step), .hi_nib(hi_nib), .line_last(line_last),
    .bidx(bidx), .tile_col(tile_col), .map_data(map_data), .pat_data(pat_data),
    .start(start), .map_rd(map_rd), .map_addr(map_addr), .pat_rd(pat_rd),
    .pat_addr(pat_addr), .cur_byte(cur_byte), .cur_ram(cur_ram), .busy(fetch_busy)
  );

  tmf_shift u_shift (
    .running(running), .hi_nib(hi_nib), .cur_byte(cur_byte), .cur_ram(cur_ram),
    .pix(pix), .pix_valid(pix_valid), .ram_tile(ram_tile)
  );

  assign busy_w = fetch_busy || running;
endmodule

// File: rtl/tmf_checker.sv
module tmf_checker import tmf_pkg::*; #(
  parameter int MAP_AW    = 9,
  parameter int MAP_WORDS = 288
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              buf_act,
  input logic              busy,
  input logic              pix_step,
  input logic              line_last,
  input logic              map_rd,
  input logic              pat_rd,
  input logic [MAP_AW-1:0] map_addr,
  input logic [PIX_W-1:0]  pix,
  input logic              pix_valid,
  input logic              ram_tile
);
  // R8: blank colour whenever no pixel is active
  a_r8_blank_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> (pix == '0));

  // R1: a pixel holds until the divider steps
  a_r1_pixel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_step) |=> (pix_valid && $stable(pix)));

  // R5: no gap inside a line
  a_r5_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !line_last) |=> pix_valid);

  // R7: flag only alongside active pixels
  a_r7_flag_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    ram_tile |-> pix_valid);

  // R9: memories are quiet while no line is being built
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!map_rd && !pat_rd));

  // R4: map reads stay inside the two buffers
  a_r4_map_range: assert property (@(posedge clk) disable iff (!rst_n)
    map_rd |-> (map_addr < MAP_AW'(MAP_WORDS)));

  // R6: displayed buffer changes only on a frame start
  a_r6_buf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(buf_act));
endmodule

bind tilemap_pixel_fetch tmf_checker #(
  .MAP_AW(MAP_AW), .MAP_WORDS(2 * TILES_X * TILES_Y)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .buf_act(buf_act),
  .busy(busy_w), .pix_step(pix_step), .line_last(line_last), .map_rd(map_rd),
  .pat_rd(pat_rd), .map_addr(map_addr), .pix(pix), .pix_valid(pix_valid),
  .ram_tile(ram_tile)
);

// File: tb/tilemap_pixel_fetch_test.sv
`timescale 1ns/1ps
module tilemap_pixel_fetch_test;
  localparam int TX     = 4;
  localparam int TY     = 3;
  localparam int CPP    = 3;
  localparam int MAW    = $clog2(2 * TX * TY);
  localparam int NWORDS = 2 * TX * TY;
  localparam int NPX    = TX * 8;
  localparam int NLINES = TY * 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_start = 1'b0, line_start = 1'b0, buf_sel = 1'b0;
  logic map_rd, pat_rd, pix_valid, ram_tile;
  logic [MAW-1:0] map_addr;
  logic [15:0] map_data, pat_addr;
  logic [7:0] pat_data;
  logic [3:0] pix;

  logic [15:0] mapm [0:NWORDS-1];
  int nchecks = 0, nerr = 0, map_reads = 0, pat_reads = 0;

  always #2 clk = ~clk;

  tilemap_pixel_fetch #(.TILES_X(TX), .TILES_Y(TY), .CLK_PER_PIX(CPP)) uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
    .buf_sel(buf_sel), .map_rd(map_rd), .map_addr(map_addr), .map_data(map_data),
    .pat_rd(pat_rd), .pat_addr(pat_addr), .pat_data(pat_data), .pix(pix),
    .pix_valid(pix_valid), .ram_tile(ram_tile)
  );

  function automatic logic [7:0] patv(logic [15:0] a);
    logic [7:0] m;
    m = 8'(a[7:0] * 8'd29);
    return m ^ a[15:8] ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (map_rd) begin
      map_data <= (int'(map_addr) < NWORDS) ? mapm[map_addr] : 16'hDEAD;
      map_reads++;
    end
    if (pat_rd) begin
      pat_data <= patv(pat_addr);
      pat_reads++;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int map_index(int b, int y, int x);
    return b * TX * TY + (y / 8) * TX + x / 8;
  endfunction

  function automatic logic [3:0] exp_pix(int b, int y, int x);
    logic [15:0] a;
    logic [7:0]  d;
    a = mapm[map_index(b, y, x)] + 16'((y % 8) * 4 + (x % 8) / 2);
    d = patv(a);
    return (x % 2 == 1) ? d[7:4] : d[3:0];
  endfunction

  // y: line index since frame start, b: buffer the line must come from
  task automatic run_line(input int y, input int b, input string tag);
    int m0, p0;
    logic vis;
    logic [3:0] e;
    logic er;
    vis = (y < NLINES);
    m0 = map_reads;
    p0 = pat_reads;
    @(negedge clk); line_start = 1'b1;
    @(negedge clk); line_start = 1'b0;
    repeat (3) @(negedge clk);
    for (int k = 0; k < NPX; k++) begin
      for (int c = 0; c < CPP; c++) begin
        if (vis) begin
          e  = exp_pix(b, y, k);
          er = mapm[map_index(b, y, k)][7];
          chk(pix === e, {tag, " R1 R2 R3 R4 pixel"}, int'(pix), int'(e));
          chk(pix_valid === 1'b1, "R5 valid in window", int'(pix_valid), 1);
          chk(ram_tile === er, "R7 ram flag", int'(ram_tile), int'(er));
        end else begin
          chk(pix === 4'h0 && pix_valid === 1'b0 && ram_tile === 1'b0,
              "R8 line past visible rows", int'({ram_tile, pix_valid, pix}), 0);
        end
        @(negedge clk);
      end
    end
    chk(pix === 4'h0 && pix_valid === 1'b0, "R8 R5 blank after window",
        int'({pix_valid, pix}), 0);
    chk(map_reads - m0 == (vis ? TX : 0), "R9 map reads", map_reads - m0, vis ? TX : 0);
    chk(pat_reads - p0 == (vis ? 4 * TX : 0), "R9 pattern reads",
        pat_reads - p0, vis ? 4 * TX : 0);
  endtask

  task automatic new_frame(input logic b);
    @(negedge clk); buf_sel = b; frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NWORDS; i++) begin
      logic [7:0] lo;
      case (i % 3)
        0:       lo = 8'(8'hF0 + (i % 16));
        1:       lo = 8'(8'h10 + i);
        default: lo = 8'(8'h90 - i);
      endcase
      mapm[i] = {8'(i * 13 + 1), lo};
    end
    repeat (4) @(negedge clk);
    chk(pix === 4'h0 && pix_valid === 1'b0 && ram_tile === 1'b0,
        "R8 reset outputs", int'({ram_tile, pix_valid, pix}), 0);
    chk(map_rd === 1'b0 && pat_rd === 1'b0, "R9 no reads in reset",
        int'({map_rd, pat_rd}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // frame on buffer 0; select flips mid-frame and must be ignored (R6)
    new_frame(1'b0);
    for (int y = 0; y < NLINES + 2; y++) begin
      if (y == 5) buf_sel = 1'b1;
      run_line(y, 0, "R6");
    end

    // frame on buffer 1; select flips back mid-frame
    new_frame(1'b1);
    for (int y = 0; y < NLINES + 2; y++) begin
      if (y == 9) buf_sel = 1'b0;
      run_line(y, 1, "R6");
    end

    // short frame, then a new frame restarts at line 0 (R10)
    new_frame(1'b0);
    for (int y = 0; y < 10; y++) run_line(y, 0, "R4");
    new_frame(1'b1);
    for (int y = 0; y < NLINES + 1; y++) run_line(y, 1, "R10");

    finish_run();
  end
endmodule